// File: doc/BRIEF.md
# LIN Frame Command Sequencer

This block holds the command bits of a LIN-style serial controller and runs the frame sequence that they select. Software sets bits through a simple write port. An external trigger can set the transmit-header bit with no software action. A control FSM starts a header, response or wakeup phase on separate abstract engines, with a start strobe out and done/error inputs back. It raises a one-cycle pulse for each finished phase. It also raises a pulse when a received header's identifier byte is available. The command bits clear themselves when the sequence ends. On an error, only some of the bits clear.

The command bits are write-one-to-set. A write whose result would be an illegal combination is dropped as a whole and flagged. Once the header ends, a transmit-response request wins over a pending receive-response request. A node that receives a header can therefore turn the frame around after the identifier arrives. In UART mode a header command moves one data field and there is never a response phase.

Top module: `lin_cmd_seq`

## Requirements
- R1: After reset every command bit reads 0. The bit positions are: transmit header = bit 0, transmit response = bit 1, transmit wakeup = bit 2, receive header = bit 8, receive response = bit 9. All other bits of `cmdBits` always read 0. A write sets the bits that are 1 in `wrData`; zeros in `wrData` clear nothing.
- R2: In LIN mode the command word must be one of these legal values: none; tx header; tx header + tx response; tx header + rx response; rx header; rx header + tx response; rx header + rx response; rx header + rx response + tx response; rx response; tx wakeup. A write or trigger whose result is not legal leaves `cmdBits` unchanged, starts nothing, and raises `illegalP` for one cycle.
- R3: When idle, the wakeup bit starts a wakeup phase (`wakeStart`). Otherwise a header bit starts a header phase (`hdrStart`), with `hdrTx` = 1 for a transmit header. A lone receive-response bit starts nothing. At most one start strobe is high in any cycle, and each lasts one cycle.
- R4: `hdrDone` raises `hdrDoneP`. During a receive header, `hdrPidRdy` raises `pidP`.
- R5: When the header ends in LIN mode with a response bit set, `rspStart` pulses in the same cycle as `hdrDoneP`. `rspTx` = 1 whenever the transmit-response bit is set, even if the receive-response bit is also set.
- R6: When a sequence completes (header with no response, response done, or wakeup done), all command bits clear. `rspDoneP` or `wakeDoneP` pulses as the phase requires.
- R7: On an engine error, `errP` pulses and the transmit header, transmit response and wakeup bits clear. The receive response bit is kept, and in LIN mode so is the receive header bit. Kept receive bits re-arm a new header phase.
- R8: In UART mode only "tx header alone" and "rx header alone" are legal. There is never a response phase. An error also clears the receive header bit.
- R9: `trigIn` is synchronized, and its rising edge sets the transmit header bit once. Holding it high does not set the bit again.
- R10: When a write and a hardware clear fall in the same cycle, bits written as 1 end up set.
- R11: A wakeup phase ends on `wakeDone`, or on `wakeErr`, which is treated as an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| uartMode | input | 1 | 1 = UART single-field mode, 0 = LIN mode |
| wrEn | input | 1 | Command write strobe |
| wrData | input | CMD_W | Command write data (write-one-to-set) |
| trigIn | input | 1 | Asynchronous hardware trigger for a transmit header |
| cmdBits | output | CMD_W | Current command bits |
| illegalP | output | 1 | Pulse: rejected command write or trigger |
| hdrStart | output | 1 | Pulse: start header engine |
| hdrTx | output | 1 | Header direction (1 = transmit) |
| hdrPidRdy | input | 1 | Header engine: identifier byte received |
| hdrDone | input | 1 | Header engine: identifier stop bit done |
| hdrErr | input | 1 | Header engine: error |
| rspStart | output | 1 | Pulse: start response engine |
| rspTx | output | 1 | Response direction (1 = transmit) |
| rspDone | input | 1 | Response engine: checksum stop bit done |
| rspErr | input | 1 | Response engine: error |
| wakeStart | output | 1 | Pulse: start wakeup generator |
| wakeDone | input | 1 | Wakeup generator finished |
| wakeErr | input | 1 | Wakeup generator error |
| hdrDoneP | output | 1 | Pulse: header phase done |
| pidP | output | 1 | Pulse: received identifier available |
| rspDoneP | output | 1 | Pulse: response phase done |
| wakeDoneP | output | 1 | Pulse: wakeup phase done |
| errP | output | 1 | Pulse: phase ended in error |

## Verification
Some properties are checked in every cycle. Start strobes are mutually exclusive. Bits outside the command field stay zero. A rejected write leaves the word stable. A response start always coincides with a header done and follows the transmit-response priority. An error never drops the receive-response bit. UART mode never starts a response. Other behaviour can only be shown by the bench's scenarios: the full legality table under random writes, the restart after an error with receive bits kept, the trigger's one-shot behaviour while held high, and a write landing in the same cycle as a completion clear.

// File: rtl/lin_cmd_pkg.sv
package lin_cmd_pkg;

  // Bit positions inside the command word (software decodes these)
  localparam int BIT_TXH = 0;
  localparam int BIT_TXR = 1;
  localparam int BIT_TXW = 2;
  localparam int BIT_RXH = 8;
  localparam int BIT_RXR = 9;

  typedef struct packed {
    logic rxRsp;
    logic rxHdr;
    logic txWake;
    logic txRsp;
    logic txHdr;
  } cmdVec_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_RSP,
    ST_WAKE
  } seqState_t;

  // Strobes from control to the command datapath
  typedef struct packed {
    logic clrAll;
    logic clrErr;
  } clrStrobe_t;

  function automatic logic cmdLegal(input cmdVec_t c, input logic uart);
    logic [4:0] v;
    logic ok;
    v = c;
    if (uart) begin
      ok = (v == 5'b00000) || (v == 5'b00001) || (v == 5'b01000);
    end else begin
      case (v)
        5'b00000, 5'b00001, 5'b00011, 5'b10001, 5'b01000,
        5'b01010, 5'b11000, 5'b11010, 5'b10000, 5'b00100: ok = 1'b1;
        default: ok = 1'b0;
      endcase
    end
    return ok;
  endfunction

endpackage

// File: rtl/lin_cmd_regs.sv
module lin_cmd_regs
  import lin_cmd_pkg::*;
#(
  parameter int CMD_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             uartMode,
  input  logic             wrEn,
  input  logic [CMD_W-1:0] wrData,
  input  logic             trigIn,
  input  clrStrobe_t       strb,
  output logic [CMD_W-1:0] cmdBits,
  output cmdVec_t          cmdVec,
  output logic             illegalP
);

  localparam logic [CMD_W-1:0] ONE       = CMD_W'(1);
  localparam logic [CMD_W-1:0] M_TXH     = ONE << BIT_TXH;
  localparam logic [CMD_W-1:0] M_TXR     = ONE << BIT_TXR;
  localparam logic [CMD_W-1:0] M_TXW     = ONE << BIT_TXW;
  localparam logic [CMD_W-1:0] M_RXH     = ONE << BIT_RXH;
  localparam logic [CMD_W-1:0] M_RXR     = ONE << BIT_RXR;
  localparam logic [CMD_W-1:0] M_TX_ALL  = M_TXH | M_TXR | M_TXW;
  localparam logic [CMD_W-1:0] M_CMD_ALL = M_TX_ALL | M_RXH | M_RXR;

  // Trigger synchronizer chain
  logic [SYNC_STAGES-1:0] trigSync;
  logic                   trigPrev;
  logic                   trigRise;

  always_ff @(posedge clk) begin
    if (!rstN) trigSync[0] <= 1'b0;
    else       trigSync[0] <= trigIn;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) trigSync[s] <= 1'b0;
      else       trigSync[s] <= trigSync[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) trigPrev <= 1'b0;
    else       trigPrev <= trigSync[SYNC_STAGES-1];
  end

  assign trigRise = trigSync[SYNC_STAGES-1] & ~trigPrev;

  // Command word update
  logic [CMD_W-1:0] cmdQ;
  logic [CMD_W-1:0] clrMask;
  logic [CMD_W-1:0] keptBits;
  logic [CMD_W-1:0] setBits;
  logic [CMD_W-1:0] candBits;
  logic [CMD_W-1:0] cmdNext;
  cmdVec_t          candVec;
  logic             candOk;
  logic             rejectD;

  function automatic cmdVec_t toVec(input logic [CMD_W-1:0] w);
    cmdVec_t r;
    r.rxRsp  = w[BIT_RXR];
    r.rxHdr  = w[BIT_RXH];
    r.txWake = w[BIT_TXW];
    r.txRsp  = w[BIT_TXR];
    r.txHdr  = w[BIT_TXH];
    return r;
  endfunction

  always_comb begin
    if (strb.clrAll)      clrMask = M_CMD_ALL;
    else if (strb.clrErr) clrMask = M_TX_ALL | (uartMode ? M_RXH : '0);
    else                  clrMask = '0;
    keptBits = cmdQ & ~clrMask;
    setBits  = (wrEn ? (wrData & M_CMD_ALL) : '0) | (trigRise ? M_TXH : '0);
    candBits = keptBits | setBits;
    candVec  = toVec(candBits);
    candOk   = cmdLegal(candVec, uartMode);
    rejectD  = (setBits != '0) && !candOk;
    cmdNext  = rejectD ? keptBits : candBits;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ     <= '0;
      illegalP <= 1'b0;
    end else begin
      cmdQ     <= cmdNext;
      illegalP <= rejectD;
    end
  end

  assign cmdBits = cmdQ;
  assign cmdVec  = toVec(cmdQ);

endmodule

// File: rtl/lin_cmd_fsm.sv
module lin_cmd_fsm
  import lin_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       uartMode,
  input  cmdVec_t    cmdVec,
  input  logic       hdrPidRdy,
  input  logic       hdrDone,
  input  logic       hdrErr,
  input  logic       rspDone,
  input  logic       rspErr,
  input  logic       wakeDone,
  input  logic       wakeErr,
  output clrStrobe_t strb,
  output logic       hdrStart,
  output logic       hdrTx,
  output logic       rspStart,
  output logic       rspTx,
  output logic       wakeStart,
  output logic       hdrDoneP,
  output logic       pidP,
  output logic       rspDoneP,
  output logic       wakeDoneP,
  output logic       errP
);

  seqState_t stateQ, stateD;
  logic goHdr, goRsp, goWake;
  logic hdrOkD, pidD, rspOkD, wakeOkD, errD;

  always_comb begin
    stateD      = stateQ;
    strb        = '0;
    goHdr       = 1'b0;
    goRsp       = 1'b0;
    goWake      = 1'b0;
    hdrOkD      = 1'b0;
    pidD        = 1'b0;
    rspOkD      = 1'b0;
    wakeOkD     = 1'b0;
    errD        = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        if (cmdVec.txWake) begin
          goWake = 1'b1;
          stateD = ST_WAKE;
        end else if (cmdVec.txHdr || cmdVec.rxHdr) begin
          goHdr  = 1'b1;
          stateD = ST_HDR;
        end
      end
      ST_HDR: begin
        pidD = hdrPidRdy && !hdrTx && !hdrErr;
        if (hdrErr) begin
          errD        = 1'b1;
          strb.clrErr = 1'b1;
          stateD      = ST_IDLE;
        end else if (hdrDone) begin
          hdrOkD = 1'b1;
          if (!uartMode && (cmdVec.txRsp || cmdVec.rxRsp)) begin
            goRsp  = 1'b1;
            stateD = ST_RSP;
          end else begin
            strb.clrAll = 1'b1;
            stateD      = ST_IDLE;
          end
        end
      end
      ST_RSP: begin
        if (rspErr) begin
          errD        = 1'b1;
          strb.clrErr = 1'b1;
          stateD      = ST_IDLE;
        end else if (rspDone) begin
          rspOkD      = 1'b1;
          strb.clrAll = 1'b1;
          stateD      = ST_IDLE;
        end
      end
      ST_WAKE: begin
        if (wakeErr) begin
          errD        = 1'b1;
          strb.clrErr = 1'b1;
          stateD      = ST_IDLE;
        end else if (wakeDone) begin
          wakeOkD     = 1'b1;
          strb.clrAll = 1'b1;
          stateD      = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      hdrStart  <= 1'b0;
      hdrTx     <= 1'b0;
      rspStart  <= 1'b0;
      rspTx     <= 1'b0;
      wakeStart <= 1'b0;
      hdrDoneP  <= 1'b0;
      pidP      <= 1'b0;
      rspDoneP  <= 1'b0;
      wakeDoneP <= 1'b0;
      errP      <= 1'b0;
    end else begin
      stateQ    <= stateD;
      hdrStart  <= goHdr;
      rspStart  <= goRsp;
      wakeStart <= goWake;
      if (goHdr) hdrTx <= cmdVec.txHdr;
      if (goRsp) rspTx <= cmdVec.txRsp;
      hdrDoneP  <= hdrOkD;
      pidP      <= pidD;
      rspDoneP  <= rspOkD;
      wakeDoneP <= wakeOkD;
      errP      <= errD;
    end
  end

endmodule

// File: rtl/lin_cmd_seq.sv
module lin_cmd_seq
  import lin_cmd_pkg::*;
#(
  parameter int CMD_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             uartMode,
  input  logic             wrEn,
  input  logic [CMD_W-1:0] wrData,
  input  logic             trigIn,
  output logic [CMD_W-1:0] cmdBits,
  output logic             illegalP,
  output logic             hdrStart,
  output logic             hdrTx,
  input  logic             hdrPidRdy,
  input  logic             hdrDone,
  input  logic             hdrErr,
  output logic             rspStart,
  output logic             rspTx,
  input  logic             rspDone,
  input  logic             rspErr,
  output logic             wakeStart,
  input  logic             wakeDone,
  input  logic             wakeErr,
  output logic             hdrDoneP,
  output logic             pidP,
  output logic             rspDoneP,
  output logic             wakeDoneP,
  output logic             errP
);

  clrStrobe_t strb;
  cmdVec_t    cmdVec;

  lin_cmd_regs #(
    .CMD_W      (CMD_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) regs_i (
    .clk     (clk),
    .rstN    (rstN),
    .uartMode(uartMode),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .trigIn  (trigIn),
    .strb    (strb),
    .cmdBits (cmdBits),
    .cmdVec  (cmdVec),
    .illegalP(illegalP)
  );

  lin_cmd_fsm fsm_i (
    .clk      (clk),
    .rstN     (rstN),
    .uartMode (uartMode),
    .cmdVec   (cmdVec),
    .hdrPidRdy(hdrPidRdy),
    .hdrDone  (hdrDone),
    .hdrErr   (hdrErr),
    .rspDone  (rspDone),
    .rspErr   (rspErr),
    .wakeDone (wakeDone),
    .wakeErr  (wakeErr),
    .strb     (strb),
    .hdrStart (hdrStart),
    .hdrTx    (hdrTx),
    .rspStart (rspStart),
    .rspTx    (rspTx),
    .wakeStart(wakeStart),
    .hdrDoneP (hdrDoneP),
    .pidP     (pidP),
    .rspDoneP (rspDoneP),
    .wakeDoneP(wakeDoneP),
    .errP     (errP)
  );

endmodule

// File: rtl/lin_cmd_seq_chk.sv
module lin_cmd_seq_chk
  import lin_cmd_pkg::*;
#(
  parameter int CMD_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             uartMode,
  input logic             wrEn,
  input logic [CMD_W-1:0] cmdBits,
  input logic             illegalP,
  input logic             hdrStart,
  input logic             rspStart,
  input logic             rspTx,
  input logic             wakeStart,
  input logic             hdrDoneP,
  input logic             rspDoneP,
  input logic             wakeDoneP,
  input logic             errP
);

  localparam logic [CMD_W-1:0] USED = (CMD_W'(1) << BIT_TXH) | (CMD_W'(1) << BIT_TXR) |
                                      (CMD_W'(1) << BIT_TXW) | (CMD_W'(1) << BIT_RXH) |
                                      (CMD_W'(1) << BIT_RXR);

  a_r1_unused_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cmdBits & ~USED) == '0);

  a_r3_start_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({hdrStart, rspStart, wakeStart}));

  a_r2_reject_stable: assert property (@(posedge clk) disable iff (!rstN)
    (illegalP && !hdrDoneP && !rspDoneP && !wakeDoneP && !errP) |-> $stable(cmdBits));

  a_r5_rsp_with_hdr_done: assert property (@(posedge clk) disable iff (!rstN)
    rspStart |-> hdrDoneP);

  a_r5_tx_priority: assert property (@(posedge clk) disable iff (!rstN)
    (rspStart && $past(cmdBits[BIT_TXR])) |-> rspTx);

  a_r7_err_keeps_rxrsp: assert property (@(posedge clk) disable iff (!rstN)
    (errP && $past(cmdBits[BIT_RXR])) |-> cmdBits[BIT_RXR]);

  a_r7_err_clears_tx: assert property (@(posedge clk) disable iff (!rstN)
    (errP && !$past(wrEn)) |-> (cmdBits[BIT_TXR] == 1'b0 && cmdBits[BIT_TXW] == 1'b0));

  a_r8_uart_no_rsp: assert property (@(posedge clk) disable iff (!rstN)
    $past(uartMode) |-> !rspStart);

endmodule

bind lin_cmd_seq lin_cmd_seq_chk #(.CMD_W(CMD_W)) chk_i (.*);

// File: tb/lin_cmd_seq_tb_top.sv
module lin_cmd_seq_tb_top;

  localparam int W = 16;

  logic clk = 1'b0;
  logic rstN;
  logic uartMode, wrEn, trigIn;
  logic [W-1:0] wrData;
  logic [W-1:0] cmdBits;
  logic illegalP, hdrStart, hdrTx, rspStart, rspTx, wakeStart;
  logic hdrPidRdy, hdrDone, hdrErr, rspDone, rspErr, wakeDone, wakeErr;
  logic hdrDoneP, pidP, rspDoneP, wakeDoneP, errP;

  int nChk = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  lin_cmd_seq dut_i (
    .clk(clk), .rstN(rstN), .uartMode(uartMode), .wrEn(wrEn), .wrData(wrData),
    .trigIn(trigIn), .cmdBits(cmdBits), .illegalP(illegalP),
    .hdrStart(hdrStart), .hdrTx(hdrTx), .hdrPidRdy(hdrPidRdy), .hdrDone(hdrDone),
    .hdrErr(hdrErr), .rspStart(rspStart), .rspTx(rspTx), .rspDone(rspDone),
    .rspErr(rspErr), .wakeStart(wakeStart), .wakeDone(wakeDone), .wakeErr(wakeErr),
    .hdrDoneP(hdrDoneP), .pidP(pidP), .rspDoneP(rspDoneP), .wakeDoneP(wakeDoneP),
    .errP(errP)
  );

  localparam int E_PID = 0, E_HDONE = 1, E_HERR = 2, E_RDONE = 3, E_RERR = 4,
                 E_WDONE = 5, E_WERR = 6;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrCmd(input logic [W-1:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic drvEng(input int sel);
    case (sel)
      E_PID:   hdrPidRdy = 1'b1;
      E_HDONE: hdrDone   = 1'b1;
      E_HERR:  hdrErr    = 1'b1;
      E_RDONE: rspDone   = 1'b1;
      E_RERR:  rspErr    = 1'b1;
      E_WDONE: wakeDone  = 1'b1;
      default: wakeErr   = 1'b1;
    endcase
    @(negedge clk);
    {hdrPidRdy, hdrDone, hdrErr, rspDone, rspErr, wakeDone, wakeErr} = '0;
  endtask

  // Legality derived from the requirement text
  function automatic logic expLegal(input logic [W-1:0] v, input logic uart);
    logic th, tr, tw, rh, rr;
    th = v[0]; tr = v[1]; tw = v[2]; rh = v[8]; rr = v[9];
    if (uart) return (v == 16'h0000) || (v == 16'h0001) || (v == 16'h0100);
    if (tw) return !(th || tr || rh || rr);
    if (th && rh) return 1'b0;
    if (th) return !(tr && rr);
    if (rh) return 1'b1;
    return !tr;
  endfunction

  task automatic finishSummary();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired");
    finishSummary();
  end

  initial begin
    logic [W-1:0] v;
    logic u;
    void'($urandom(32'h5EED_1234));
    rstN = 1'b0; uartMode = 1'b0; wrEn = 1'b0; wrData = '0; trigIn = 1'b0;
    {hdrPidRdy, hdrDone, hdrErr, rspDone, rspErr, wakeDone, wakeErr} = '0;
    step(3);
    rstN = 1'b1;
    step(1);
    chk("R1 reset cmd", cmdBits, 16'h0);
    chk("R1 reset starts", {hdrStart, rspStart, wakeStart}, 0);

    // R1: a write of zeros clears nothing; unused bits read 0
    wrCmd(16'hFC00 | 16'h0001);
    chk("R1 unused bits masked", cmdBits, 16'h0001);
    step(1);
    chk("R3 tx header start", {hdrStart, hdrTx}, 2'b11);
    wrCmd(16'h0000);
    chk("R1 zero write keeps", cmdBits, 16'h0001);
    drvEng(E_HDONE);
    chk("R4 hdr done pulse", hdrDoneP, 1);
    chk("R6 hdr alone clears", cmdBits, 16'h0);
    chk("R5 no rsp for hdr alone", rspStart, 0);

    // tx header + tx response
    wrCmd(16'h0003);
    step(1);
    drvEng(E_HDONE);
    chk("R5 tx rsp start", {rspStart, rspTx}, 2'b11);
    drvEng(E_RDONE);
    chk("R6 rsp done pulse", rspDoneP, 1);
    chk("R6 cleared after rsp", cmdBits, 16'h0);

    // rx header + rx response, turned around after the identifier
    wrCmd(16'h0300);
    step(1);
    chk("R3 rx header start", {hdrStart, hdrTx}, 2'b10);
    drvEng(E_PID);
    chk("R4 pid pulse", pidP, 1);
    wrCmd(16'h0002);
    chk("R2 late tx rsp accepted", cmdBits, 16'h0302);
    drvEng(E_HDONE);
    chk("R5 tx over rx priority", {rspStart, rspTx}, 2'b11);
    drvEng(E_RDONE);
    chk("R6 cleared after turnaround", cmdBits, 16'h0);

    // response error keeps receive bits and re-arms
    wrCmd(16'h0300);
    step(1);
    drvEng(E_HDONE);
    chk("R5 rx rsp start", {rspStart, rspTx}, 2'b10);
    drvEng(E_RERR);
    chk("R7 err pulse", errP, 1);
    chk("R7 rx bits kept", cmdBits, 16'h0300);
    step(1);
    chk("R7 re-armed header", hdrStart, 1);
    drvEng(E_HDONE);
    drvEng(E_RDONE);
    chk("R6 cleared after rearm", cmdBits, 16'h0);

    // header error keeps rx response only
    wrCmd(16'h0201);
    step(1);
    drvEng(E_HERR);
    chk("R7 tx cleared rx rsp kept", cmdBits, 16'h0200);
    step(2);
    chk("R3 lone rx rsp idle", {hdrStart, rspStart, wakeStart}, 0);
    wrCmd(16'h0100);
    chk("R2 rx hdr added", cmdBits, 16'h0300);
    step(1);
    chk("R3 rx header after add", {hdrStart, hdrTx}, 2'b10);
    drvEng(E_HDONE);
    drvEng(E_RDONE);
    chk("R6 cleared", cmdBits, 16'h0);

    // wakeup
    wrCmd(16'h0004);
    step(1);
    chk("R3 wake start", wakeStart, 1);
    drvEng(E_WDONE);
    chk("R11 wake done pulse", wakeDoneP, 1);
    chk("R11 wake clears", cmdBits, 16'h0);
    wrCmd(16'h0004);
    step(1);
    drvEng(E_WERR);
    chk("R11 wake err", {errP, cmdBits}, {1'b1, 16'h0});

    // illegal writes
    wrCmd(16'h0005);
    chk("R2 illegal ignored", cmdBits, 16'h0);
    chk("R2 illegal flagged", illegalP, 1);
    step(1);
    chk("R2 no start on illegal", {hdrStart, wakeStart, illegalP}, 0);
    wrCmd(16'h0103);
    chk("R2 illegal mix", {illegalP, cmdBits}, {1'b1, 16'h0});

    // UART mode
    uartMode = 1'b1;
    wrCmd(16'h0300);
    chk("R8 uart rejects rx pair", {illegalP, cmdBits}, {1'b1, 16'h0});
    wrCmd(16'h0100);
    step(1);
    chk("R8 uart rx start", {hdrStart, hdrTx}, 2'b10);
    drvEng(E_HERR);
    chk("R8 uart err clears rx hdr", cmdBits, 16'h0);
    wrCmd(16'h0001);
    step(1);
    drvEng(E_HDONE);
    chk("R8 uart single field", {hdrDoneP, rspStart, cmdBits}, {2'b10, 16'h0});
    uartMode = 1'b0;

    // hardware trigger, held high
    trigIn = 1'b1;
    step(3);
    chk("R9 trigger sets tx hdr", cmdBits, 16'h0001);
    step(1);
    chk("R9 trigger starts header", {hdrStart, hdrTx}, 2'b11);
    drvEng(E_HDONE);
    step(6);
    chk("R9 held trigger one shot", {cmdBits, hdrStart}, {16'h0, 1'b0});
    trigIn = 1'b0;
    step(3);

    // write in the same cycle as completion clear
    wrCmd(16'h0001);
    step(1);
    hdrDone = 1'b1; wrEn = 1'b1; wrData = 16'h0001;
    @(negedge clk);
    hdrDone = 1'b0; wrEn = 1'b0; wrData = '0;
    chk("R10 write beats clear", {hdrDoneP, cmdBits}, {1'b1, 16'h0001});
    step(1);
    chk("R10 restarted", hdrStart, 1);
    drvEng(E_HDONE);
    chk("R10 final clear", cmdBits, 16'h0);

    // constrained random writes from idle
    for (int i = 0; i < 80; i++) begin
      v = '0;
      v[0] = $urandom % 2; v[1] = $urandom % 2; v[2] = ($urandom % 4) == 0;
      v[8] = $urandom % 2; v[9] = $urandom % 2;
      u = ($urandom % 5) == 0;
      uartMode = u;
      wrCmd(v);
      if (expLegal(v, u)) begin
        chk("R2 random legal", {illegalP, cmdBits}, {1'b0, v});
      end else begin
        chk("R2 random illegal", {illegalP, cmdBits}, {(v != 0), 16'h0});
        v = '0;
      end
      step(1);
      if (v[2])               chk("R3 random wake", {wakeStart, hdrStart}, 2'b10);
      else if (v[0] || v[8])  chk("R3 random hdr", {hdrStart, hdrTx, wakeStart}, {1'b1, v[0], 1'b0});
      else                    chk("R3 random none", {hdrStart, wakeStart}, 0);
      for (int k = 0; k < 40; k++) begin
        if (cmdBits == 16'h0) break;
        if (cmdBits == 16'h0200) begin
          wrCmd(16'h0100);
        end else if (hdrStart) begin
          drvEng(E_HDONE);
          if (rspStart) chk("R5 random rsp dir", rspTx, v[1]);
        end else if (rspStart) begin
          drvEng(E_RDONE);
        end else if (wakeStart) begin
          drvEng(E_WDONE);
        end else begin
          step(1);
        end
      end
      chk("R6 random drained", cmdBits, 16'h0);
    end
    uartMode = 1'b0;
    step(2);
    finishSummary();
  end

endmodule